// File: doc/BRIEF.md
# Vending Release Sequencer (Moore / Mealy selectable)

This block sequences one vend cycle. After reset it spends one cycle wiping an external credit accumulator. It then idles until a single-bit credit-sufficient flag goes high, and then it fires a release strobe toward the dispensing mechanism. The cycle then repeats from the wipe step.

The parameter `MEALY` selects one of two forms that share the same ports. With `MEALY = 0` the controller is a three-state Moore machine (wipe, idle, release), and each output comes from the state alone. With `MEALY = 1` it is a two-state Mealy machine (wipe, idle). In that form the release strobe is decoded from the idle state together with the live input, so it appears in the cycle the flag rises. Coin handling, the accumulator and any price comparison sit outside the block.

Top module: `vend_release_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the machine enters the wipe state: after that edge `wipe_o`=1 and `release_o`=0 in both forms, whatever state it was in before.
- R2: The wipe state lasts exactly one cycle and is left for the idle state whatever the value of `credit_ok`; in the wipe state `release_o`=0 even when `credit_ok`=1.
- R3: In the idle state, while `credit_ok` is sampled 0 at each edge, the machine stays idle with `wipe_o`=0 and `release_o`=0.
- R4: Moore form (`MEALY`=0): when `credit_ok` is sampled 1 in the idle state, `release_o`=1 in the next cycle only, whatever `credit_ok` does in that cycle. The cycle after that is a wipe cycle.
- R5: Mealy form (`MEALY`=1): in the idle state `release_o` equals `credit_ok` within the same cycle, and an edge that samples `credit_ok`=1 there moves the machine to the wipe state.
- R6: Mealy form: a `credit_ok` pulse that rises and falls between two clock edges makes `release_o` follow it, and leaves the machine in the idle state.
- R7: `release_o` and `wipe_o` are never 1 together.
- R8: With `credit_ok` held at 1 from reset release onward, the outputs repeat with period 3 in the Moore form (wipe, idle, release) and with period 2 in the Mealy form (wipe, release).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| credit_ok | input | 1 | Credit is sufficient for a vend |
| release_o | output | 1 | Strobe that releases the item |
| wipe_o | output | 1 | Strobe that clears the external credit accumulator |

## Verification
The hardest case to reach from the ports is the Mealy release that exists only inside one clock period. It needs `credit_ok` to rise after one edge and fall before the next, so that the strobe is seen but no edge ever samples it. The bench drives the flag at the falling edge, checks the strobe a fraction of a nanosecond later, drops the flag again before the rising edge, and then confirms that the machine is still idle. A second case is hard to reach as well: an input held high through the wipe step and the Moore release step. Because the flag is asserted while reset is still held, those states are entered with the flag already high.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

    typedef enum logic [1:0] {
        ST_WIPE    = 2'd0,
        ST_IDLE    = 2'd1,
        ST_RELEASE = 2'd2
    } vrc_state_t;

    typedef struct packed {
        logic release_s;
        logic wipe_s;
    } vrc_outs_t;

    // Next state for either form; the Mealy form never enters ST_RELEASE.
    function automatic vrc_state_t vrc_next(input vrc_state_t cur,
                                             input logic credit,
                                             input logic mealy);
        vrc_state_t nxt;
        unique case (cur)
            ST_WIPE:    nxt = ST_IDLE;
            ST_IDLE:    nxt = credit ? (mealy ? ST_WIPE : ST_RELEASE) : ST_IDLE;
            ST_RELEASE: nxt = ST_WIPE;
            default:    nxt = ST_WIPE;
        endcase
        return nxt;
    endfunction

    // Output decode: Moore part from state alone, Mealy part adds the live input.
    function automatic vrc_outs_t vrc_decode(input vrc_state_t cur,
                                              input logic credit,
                                              input logic mealy);
        vrc_outs_t o;
        o.wipe_s    = (cur == ST_WIPE);
        o.release_s = (cur == ST_RELEASE) | (mealy & (cur == ST_IDLE) & credit);
        return o;
    endfunction

endpackage

// File: rtl/vrc_next_state.sv
module vrc_next_state
    import vrc_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  vrc_state_t cur_state,
    input  logic       credit_ok,
    output vrc_state_t nxt_state
);
    always_comb begin
        nxt_state = vrc_next(cur_state, credit_ok, MEALY);
    end
endmodule

// File: rtl/vrc_out_decode.sv
module vrc_out_decode
    import vrc_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  vrc_state_t cur_state,
    input  logic       credit_ok,
    output vrc_outs_t  outs
);
    always_comb begin
        outs = vrc_decode(cur_state, credit_ok, MEALY);
    end
endmodule

// File: rtl/vrc_state_reg.sv
module vrc_state_reg
    import vrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  vrc_state_t nxt_state,
    output vrc_state_t cur_state
);
    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_WIPE;
        else     cur_state <= nxt_state;
    end
endmodule

// File: rtl/vend_release_ctrl.sv
module vend_release_ctrl
    import vrc_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic credit_ok,
    output logic release_o,
    output logic wipe_o
);
    vrc_state_t cur_state;
    vrc_state_t nxt_state;
    vrc_outs_t  outs;

    vrc_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    vrc_next_state #(.MEALY(MEALY)) u_next (
        .cur_state (cur_state),
        .credit_ok (credit_ok),
        .nxt_state (nxt_state)
    );

    vrc_out_decode #(.MEALY(MEALY)) u_out (
        .cur_state (cur_state),
        .credit_ok (credit_ok),
        .outs      (outs)
    );

    assign release_o = outs.release_s;
    assign wipe_o    = outs.wipe_s;
endmodule

// File: rtl/vend_release_chk.sv
module vend_release_chk #(
    parameter bit MEALY = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic credit_ok,
    input logic release_o,
    input logic wipe_o
);
    // R1: reset lands in the wipe state
    assert_reset_wipe_R1: assert property (@(posedge clk)
        rst |=> (wipe_o && !release_o));

    // R2: wipe lasts one cycle
    assert_wipe_single_R2: assert property (@(posedge clk) disable iff (rst)
        wipe_o |=> !wipe_o);

    // R2: no release during wipe
    assert_wipe_no_release_R2: assert property (@(posedge clk) disable iff (rst)
        wipe_o |-> !release_o);

    // R3: idle with low credit stays out of wipe
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wipe_o && !release_o && !credit_ok) |=> !wipe_o);

    // R4 / R5: a release sampled at an edge is followed by a wipe cycle
    assert_release_then_wipe_R4: assert property (@(posedge clk) disable iff (rst)
        release_o |=> (wipe_o && !release_o));

    // R7: strobes mutually exclusive
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(release_o && wipe_o));

    if (MEALY) begin : g_mealy_chk
        // R5: idle plus credit gives release in the same cycle
        assert_mealy_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
            (!wipe_o && credit_ok) |-> release_o);
    end else begin : g_moore_chk
        // R4: idle plus credit gives release in the next cycle
        assert_moore_next_cycle_R4: assert property (@(posedge clk) disable iff (rst)
            (!wipe_o && !release_o && credit_ok) |=> release_o);
        // R4: release never immediately repeats
        assert_moore_single_R4: assert property (@(posedge clk) disable iff (rst)
            release_o |=> !release_o);
    end
endmodule

bind vend_release_ctrl vend_release_chk #(.MEALY(MEALY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .credit_ok (credit_ok),
    .release_o (release_o),
    .wipe_o    (wipe_o)
);

// File: tb/vend_release_ctrl_test.sv
`timescale 1ns/1ps
module vend_release_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic credit_ok = 1'b0;
    logic mo_rel, mo_wipe, me_rel, me_wipe;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    vend_release_ctrl #(.MEALY(1'b0)) uut (
        .clk(clk), .rst(rst), .credit_ok(credit_ok),
        .release_o(mo_rel), .wipe_o(mo_wipe)
    );

    vend_release_ctrl #(.MEALY(1'b1)) uut_mealy (
        .clk(clk), .rst(rst), .credit_ok(credit_ok),
        .release_o(me_rel), .wipe_o(me_wipe)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    // Outputs {release, wipe} for both forms
    task automatic check_both(input logic mr, input logic mw,
                              input logic er, input logic ew, input string req);
        check(mo_rel,  mr, {req, " moore release"});
        check(mo_wipe, mw, {req, " moore wipe"});
        check(me_rel,  er, {req, " mealy release"});
        check(me_wipe, ew, {req, " mealy wipe"});
    endtask

    // Ends at a falling edge with both machines in the wipe state.
    task automatic do_reset(input logic credit_during);
        @(negedge clk);
        rst = 1'b1;
        credit_ok = credit_during;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check_both(1'b0, 1'b1, 1'b0, 1'b1, "R1 after reset");
    endtask

    task automatic t_reset_mid_release;
        do_reset(1'b0);
        @(negedge clk);             // idle
        credit_ok = 1'b1;
        @(negedge clk);             // Moore in release state
        credit_ok = 1'b0;
        #0.5;
        check(mo_rel, 1'b1, "R1 precondition moore release");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check_both(1'b0, 1'b1, 1'b0, 1'b1, "R1 reset from release");
    endtask

    task automatic t_idle_hold;
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #0.5;
            check_both(1'b0, 1'b0, 1'b0, 1'b0, "R3 idle hold");
        end
    endtask

    task automatic t_timing;
        do_reset(1'b0);
        @(negedge clk);             // idle
        credit_ok = 1'b1;
        #0.5;
        check(me_rel, 1'b1, "R5 mealy same cycle");
        check(mo_rel, 1'b0, "R4 moore not yet");
        @(negedge clk);
        credit_ok = 1'b0;           // R4: release independent of input now
        #0.5;
        check(mo_rel,  1'b1, "R4 moore one cycle later");
        check(mo_wipe, 1'b0, "R7 moore no wipe with release");
        check(me_wipe, 1'b1, "R5 mealy into wipe");
        check(me_rel,  1'b0, "R2 mealy no release in wipe");
        @(negedge clk);
        #0.5;
        check_both(1'b0, 1'b1, 1'b0, 1'b0, "R4 moore wipe after release");
    endtask

    task automatic t_glitch;
        do_reset(1'b0);
        @(negedge clk);             // idle
        credit_ok = 1'b1;
        #0.5;
        check(me_rel, 1'b1, "R6 mealy follows rise");
        #1.0;
        credit_ok = 1'b0;
        #0.5;
        check(me_rel, 1'b0, "R6 mealy follows fall");
        @(negedge clk);
        #0.5;
        check_both(1'b0, 1'b0, 1'b0, 1'b0, "R6 still idle after pulse");
    endtask

    task automatic t_init_ignores;
        do_reset(1'b1);             // credit already high in wipe state
        @(negedge clk);
        #0.5;
        check_both(1'b0, 1'b0, 1'b1, 1'b0, "R2 wipe left despite credit");
        @(negedge clk);
        #0.5;
        check_both(1'b1, 1'b0, 1'b0, 1'b1, "R2 second step");
        credit_ok = 1'b0;
    endtask

    task automatic t_stream;
        do_reset(1'b1);
        for (int k = 0; k < 12; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #0.5;
            end
            check(mo_wipe, (k % 3) == 0, "R8 moore wipe phase");
            check(mo_rel,  (k % 3) == 2, "R8 moore release phase");
            check(me_wipe, (k % 2) == 0, "R8 mealy wipe phase");
            check(me_rel,  (k % 2) == 1, "R8 mealy release phase");
            check(mo_rel & mo_wipe, 1'b0, "R7 moore exclusive");
            check(me_rel & me_wipe, 1'b0, "R7 mealy exclusive");
        end
        credit_ok = 1'b0;
    endtask

    initial begin
        t_reset_mid_release();
        t_idle_hold();
        t_timing();
        t_glitch();
        t_init_ignores();
        t_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule